// File: doc/BRIEF.md
# DMA Channel Request and Configuration Bank

This block holds the per-channel control state of a 32-channel DMA controller and turns raw request lines into a clean pending-request vector for a downstream arbiter. Software reaches it through a simple word-addressed write port with a combinational read path. Five per-channel flags each sit behind a pair of registers, one that sets bits and one that clears them: enable, request mask, burst-only, alternate-structure select and high priority. Each channel also has a 4-bit source-select field. These fields are packed eight to a word in four map registers.

Every channel has five peripheral request inputs. The map field of the channel picks one of them. The request mask can block that peripheral trigger. A one-shot software request is then merged in, and the result is gated by the channel enable and a global master enable. The controller datapath reports back to the bank in two ways. It reports completed transfers, which set interrupt-status bits that software clears by writing 1. It can also drop a channel's burst-only flag by itself.

Word offsets (at `cfg_addr`): 0 configuration (bit 0 master enable), 1 status (read only), 2 software request (write only), 3 interrupt status, 4/5 enable set/clear, 6/7 mask set/clear, 8/9 burst-only set/clear, 10/11 alternate set/clear, 12/13 priority set/clear, 16 to 19 channel map words 0 to 3.

Top module: `dma_chan_bank`

## Requirements
- R1: After reset, all five per-channel flag vectors, the map words, the master enable and the interrupt status read 0, and `chan_pend` is 0.
- R2: A write to a set offset (4, 6, 8, 10, 12) sets each flag whose data bit is 1. A write to the matching clear offset (one higher) clears each flag whose data bit is 1. Data bits at 0 leave flags unchanged. Reading either offset of a pair returns the current flag vector.
- R3: Bit 0 of offset 0 is the master enable. Status (offset 1) returns the master enable in bit 0 and the channel count minus one in bits [20:16], with all other bits 0.
- R4: `chan_pend[n]` equals enable[n] AND master AND (software pulse[n] OR (selected peripheral line AND NOT mask[n])). It is 0 whenever the channel or the master is disabled.
- R5: A set mask bit blocks only the peripheral trigger of its channel. A software request on a masked channel still raises `chan_pend`.
- R6: Writing 1 to bit n at offset 2 raises `chan_pend[n]` for exactly the one cycle after the write edge. Offset 2 reads 0.
- R7: Channel n's select field is bits [4*(n mod 8)+3 : 4*(n mod 8)] of map word n/8 (offset 16 + n/8). A value s of 0 to 4 picks `periph_req[5*n + s]`. Peripheral lines reach `chan_pend` in the same cycle.
- R8: Select values 5 to 15 pick no request, so the peripheral path of the channel stays 0.
- R9: A high `burst_drop[n]` clears the burst-only flag of channel n at the next edge. A burst-only set write to the same bit in that cycle wins, and the flag stays 1.
- R10: A high `xfer_done[n]` sets interrupt bit n. Writing 1 to offset 3 clears the written bits. A completion in the same cycle as a clear of the same bit wins, and the bit stays 1. `chan_irq` shows the vector.
- R11: `chan_hipri`, `chan_alt` and `chan_burst` always equal the priority, alternate and burst-only flag vectors.
- R12: Offsets outside the map above read 0, and writes to them change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 6 | Word offset for read and write |
| cfg_wdata | input | 32 | Write data |
| cfg_rdata | output | 32 | Read data for `cfg_addr` (combinational) |
| periph_req | input | 160 | Peripheral request lines, five per channel, channel n at [5n+4:5n] |
| burst_drop | input | 32 | Hardware clear of burst-only flags |
| xfer_done | input | 32 | Transfer completion pulses |
| chan_pend | output | 32 | Pending request per channel |
| chan_hipri | output | 32 | High-priority flag per channel |
| chan_alt | output | 32 | Alternate-structure select per channel |
| chan_burst | output | 32 | Burst-only flag per channel |
| chan_irq | output | 32 | Interrupt status per channel |

## Verification
The bench probes the field position of the source select at both ends of the map words and in between. A design that packed fields or words wrongly would route the wrong peripheral line, and a pending request would then appear on a channel whose selected line is idle, or be missing on one whose line is high. It drives every peripheral line high with out-of-range select codes, where a mux that wraps or truncates the code would raise a request. It tests a software request on a masked channel, which a design that masked the merged request would drop, and it checks that the software pulse lasts exactly one cycle, since a sticky pulse would repeat transfers. It collides a hardware burst drop with a set write, and a completion with an interrupt clear, because a design with the opposite priority loses the flag or the event.

// File: rtl/dmab_pkg.sv
package dmab_pkg;
  localparam int OFF_CFG      = 0;
  localparam int OFF_STATUS   = 1;
  localparam int OFF_SWREQ    = 2;
  localparam int OFF_IRQ      = 3;
  localparam int OFF_FLAG0    = 4;   // pairs: set at base+2k, clear at base+2k+1
  localparam int OFF_MAP0     = 16;
  localparam int NFLAG        = 5;
  localparam int FLG_EN       = 0;
  localparam int FLG_MASK     = 1;
  localparam int FLG_BURST    = 2;
  localparam int FLG_ALT      = 3;
  localparam int FLG_PRIO     = 4;
  localparam int CNT_LSB      = 16;

  function automatic int set_off(input int k);
    return OFF_FLAG0 + 2 * k;
  endfunction

  function automatic int clr_off(input int k);
    return OFF_FLAG0 + 2 * k + 1;
  endfunction

  // map word index holding channel ch's select field
  function automatic int map_word(input int ch, input int per_word);
    return ch / per_word;
  endfunction

  // lowest bit of channel ch's select field inside its map word
  function automatic int map_lsb(input int ch, input int per_word, input int selw);
    return selw * (ch % per_word);
  endfunction
endpackage

// File: rtl/dmab_flag_vec.sv
module dmab_flag_vec #(
  parameter int N      = 32,
  parameter bit HW_CLR = 1'b0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         set_we,
  input  logic         clr_we,
  input  logic [N-1:0] wbits,
  input  logic [N-1:0] hw_clr,
  output logic [N-1:0] q
);
  logic [N-1:0] set_m, clr_m, drop_m;

  assign set_m = set_we ? wbits : '0;
  assign clr_m = clr_we ? wbits : '0;

  generate
    if (HW_CLR) begin : g_hw
      assign drop_m = hw_clr;
    end else begin : g_nohw
      assign drop_m = '0;
    end
  endgenerate

  // set wins over any clear source in the same cycle
  always_ff @(posedge clk) begin
    if (!rst_n) q <= '0;
    else        q <= (q & ~clr_m & ~drop_m) | set_m;
  end
endmodule

// File: rtl/dmab_irq_vec.sv
module dmab_irq_vec #(
  parameter int N = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         w1c_we,
  input  logic [N-1:0] wbits,
  input  logic [N-1:0] done,
  output logic [N-1:0] q
);
  logic [N-1:0] clr_m;
  assign clr_m = w1c_we ? wbits : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) q <= '0;
    else        q <= (q & ~clr_m) | done;
  end
endmodule

// File: rtl/dmab_src_mux.sv
module dmab_src_mux #(
  parameter int NSRC = 5,
  parameter int SELW = 4
) (
  input  logic [NSRC-1:0] lines,
  input  logic [SELW-1:0] sel,
  output logic            hit
);
  function automatic logic pick(input logic [NSRC-1:0] l, input logic [SELW-1:0] s);
    logic r;
    r = 1'b0;
    for (int i = 0; i < NSRC; i++)
      if (s == SELW'(i)) r = l[i];
    return r;
  endfunction

  assign hit = pick(lines, sel);
endmodule

// File: rtl/dma_chan_bank.sv
module dma_chan_bank
  import dmab_pkg::*;
#(
  parameter int NCH  = 32,
  parameter int NSRC = 5,
  parameter int SELW = 4,
  parameter int AW   = 6,
  parameter int DW   = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cfg_we,
  input  logic [AW-1:0]        cfg_addr,
  input  logic [DW-1:0]        cfg_wdata,
  output logic [DW-1:0]        cfg_rdata,
  input  logic [NCH*NSRC-1:0]  periph_req,
  input  logic [NCH-1:0]       burst_drop,
  input  logic [NCH-1:0]       xfer_done,
  output logic [NCH-1:0]       chan_pend,
  output logic [NCH-1:0]       chan_hipri,
  output logic [NCH-1:0]       chan_alt,
  output logic [NCH-1:0]       chan_burst,
  output logic [NCH-1:0]       chan_irq
);
  localparam int PER_WORD = DW / SELW;
  localparam int NMAP     = (NCH + PER_WORD - 1) / PER_WORD;
  localparam int CNTW     = $clog2(NCH) < 1 ? 1 : $clog2(NCH);

  // decoded write events, brought out for the checker
  logic             wr_cfg, wr_sw, wr_irq;
  logic [NFLAG-1:0] wr_set, wr_clr;
  logic [NMAP-1:0]  wr_map;

  logic                master_q;
  logic [NCH-1:0]      sw_pulse;
  logic [NCH-1:0]      flag_q [NFLAG];
  logic [DW-1:0]       map_q  [NMAP];
  logic [NCH-1:0]      irq_q;
  logic [NCH-1:0]      periph_hit;
  logic [NCH-1:0]      wbits;

  assign wbits  = cfg_wdata[NCH-1:0];
  assign wr_cfg = cfg_we && (cfg_addr == AW'(OFF_CFG));
  assign wr_sw  = cfg_we && (cfg_addr == AW'(OFF_SWREQ));
  assign wr_irq = cfg_we && (cfg_addr == AW'(OFF_IRQ));

  // master enable
  always_ff @(posedge clk) begin
    if (!rst_n)      master_q <= 1'b0;
    else if (wr_cfg) master_q <= cfg_wdata[0];
  end

  // one-shot software request, lives for one cycle
  always_ff @(posedge clk) begin
    if (!rst_n) sw_pulse <= '0;
    else        sw_pulse <= wr_sw ? wbits : '0;
  end

  // paired set/clear flag vectors
  generate
    for (genvar k = 0; k < NFLAG; k++) begin : g_flag
      assign wr_set[k] = cfg_we && (cfg_addr == AW'(set_off(k)));
      assign wr_clr[k] = cfg_we && (cfg_addr == AW'(clr_off(k)));
      dmab_flag_vec #(
        .N      (NCH),
        .HW_CLR (k == FLG_BURST)
      ) u_flag (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_we (wr_set[k]),
        .clr_we (wr_clr[k]),
        .wbits  (wbits),
        .hw_clr (burst_drop),
        .q      (flag_q[k])
      );
    end
  endgenerate

  dmab_irq_vec #(.N(NCH)) u_irq (
    .clk    (clk),
    .rst_n  (rst_n),
    .w1c_we (wr_irq),
    .wbits  (wbits),
    .done   (xfer_done),
    .q      (irq_q)
  );

  // channel map words
  generate
    for (genvar i = 0; i < NMAP; i++) begin : g_map
      assign wr_map[i] = cfg_we && (cfg_addr == AW'(OFF_MAP0 + i));
      always_ff @(posedge clk) begin
        if (!rst_n)         map_q[i] <= '0;
        else if (wr_map[i]) map_q[i] <= cfg_wdata;
      end
    end
  endgenerate

  // per-channel source routing
  generate
    for (genvar n = 0; n < NCH; n++) begin : g_ch
      localparam int WI  = map_word(n, PER_WORD);
      localparam int LSB = map_lsb(n, PER_WORD, SELW);
      dmab_src_mux #(.NSRC(NSRC), .SELW(SELW)) u_mux (
        .lines (periph_req[n*NSRC +: NSRC]),
        .sel   (map_q[WI][LSB +: SELW]),
        .hit   (periph_hit[n])
      );
    end
  endgenerate

  assign chan_pend  = flag_q[FLG_EN] & {NCH{master_q}} &
                      (sw_pulse | (periph_hit & ~flag_q[FLG_MASK]));
  assign chan_hipri = flag_q[FLG_PRIO];
  assign chan_alt   = flag_q[FLG_ALT];
  assign chan_burst = flag_q[FLG_BURST];
  assign chan_irq   = irq_q;

  // read path
  always_comb begin
    cfg_rdata = '0;
    if (cfg_addr == AW'(OFF_CFG)) begin
      cfg_rdata[0] = master_q;
    end else if (cfg_addr == AW'(OFF_STATUS)) begin
      cfg_rdata[0] = master_q;
      cfg_rdata[CNT_LSB +: CNTW] = CNTW'(NCH - 1);
    end else if (cfg_addr == AW'(OFF_IRQ)) begin
      cfg_rdata = DW'(irq_q);
    end
    for (int k = 0; k < NFLAG; k++)
      if (cfg_addr == AW'(set_off(k)) || cfg_addr == AW'(clr_off(k)))
        cfg_rdata = DW'(flag_q[k]);
    for (int i = 0; i < NMAP; i++)
      if (cfg_addr == AW'(OFF_MAP0 + i))
        cfg_rdata = map_q[i];
  end
endmodule

// File: rtl/dmab_chk.sv
module dmab_chk #(
  parameter int NCH = 32,
  parameter int AW  = 6,
  parameter int DW  = 32
) (
  input logic           clk,
  input logic           rst_n,
  input logic           cfg_we,
  input logic [AW-1:0]  cfg_addr,
  input logic [DW-1:0]  cfg_wdata,
  input logic           wr_sw,
  input logic           master_q,
  input logic [NCH-1:0] sw_pulse,
  input logic [NCH-1:0] burst_drop,
  input logic [NCH-1:0] xfer_done,
  input logic [NCH-1:0] chan_pend,
  input logic [NCH-1:0] chan_burst,
  input logic [NCH-1:0] chan_irq,
  input logic [NCH-1:0] en_q
);
  // R4
  pend_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (chan_pend & ~(en_q & {NCH{master_q}})) == '0);

  // R6
  sw_oneshot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_sw |=> (sw_pulse == '0));

  // R5
  sw_reach_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_sw |=> ((chan_pend & $past(cfg_wdata[NCH-1:0]) & en_q & {NCH{master_q}})
               == ($past(cfg_wdata[NCH-1:0]) & en_q & {NCH{master_q}})));

  // R10
  irq_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|xfer_done) |=> ((chan_irq & $past(xfer_done)) == $past(xfer_done)));

  // R9
  burst_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((|burst_drop) && !(cfg_we && cfg_addr == AW'(dmab_pkg::set_off(dmab_pkg::FLG_BURST))))
    |=> ((chan_burst & $past(burst_drop)) == '0));

  // R2
  en_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && cfg_addr == AW'(dmab_pkg::set_off(dmab_pkg::FLG_EN)))
    |=> ((en_q & $past(cfg_wdata[NCH-1:0])) == $past(cfg_wdata[NCH-1:0])));
endmodule

bind dma_chan_bank dmab_chk #(.NCH(NCH), .AW(AW), .DW(DW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cfg_we     (cfg_we),
  .cfg_addr   (cfg_addr),
  .cfg_wdata  (cfg_wdata),
  .wr_sw      (wr_sw),
  .master_q   (master_q),
  .sw_pulse   (sw_pulse),
  .burst_drop (burst_drop),
  .xfer_done  (xfer_done),
  .chan_pend  (chan_pend),
  .chan_burst (chan_burst),
  .chan_irq   (chan_irq),
  .en_q       (flag_q[dmab_pkg::FLG_EN])
);

// File: tb/sim_dma_chan_bank.sv
module sim_dma_chan_bank;
  localparam int NCH = 32, NSRC = 5;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              cfg_we = 1'b0;
  logic [5:0]        cfg_addr = '0;
  logic [31:0]       cfg_wdata = '0;
  logic [31:0]       cfg_rdata;
  logic [NCH*NSRC-1:0] periph_req = '0;
  logic [NCH-1:0]    burst_drop = '0, xfer_done = '0;
  logic [NCH-1:0]    chan_pend, chan_hipri, chan_alt, chan_burst, chan_irq;

  int checks = 0, errors = 0;
  logic [31:0] rv;

  always #5 clk = ~clk;

  dma_chan_bank u0 (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .periph_req(periph_req),
    .burst_drop(burst_drop), .xfer_done(xfer_done), .chan_pend(chan_pend),
    .chan_hipri(chan_hipri), .chan_alt(chan_alt), .chan_burst(chan_burst),
    .chan_irq(chan_irq)
  );

  typedef struct packed {
    logic [4:0] ch;
    logic [3:0] sel;
    logic       msk;
    logic       en;
    logic [4:0] lines;
    logic       exp;
  } vec_t;

  // routing vectors for R4, R5, R7, R8
  localparam vec_t VEC [8] = '{
    '{5'd0,  4'd0,  1'b0, 1'b1, 5'b00001, 1'b1},
    '{5'd9,  4'd4,  1'b0, 1'b1, 5'b10000, 1'b1},
    '{5'd9,  4'd4,  1'b0, 1'b1, 5'b01111, 1'b0},
    '{5'd17, 4'd2,  1'b1, 1'b1, 5'b11111, 1'b0},
    '{5'd31, 4'd7,  1'b0, 1'b1, 5'b11111, 1'b0},
    '{5'd23, 4'd3,  1'b0, 1'b0, 5'b11111, 1'b0},
    '{5'd15, 4'd1,  1'b0, 1'b1, 5'b00010, 1'b1},
    '{5'd8,  4'd15, 1'b0, 1'b1, 5'b11111, 1'b0}
  };

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = 6'(a); cfg_wdata = d;
    @(posedge clk); #1;
    cfg_we = 1'b0;
  endtask

  task automatic rd(input int a, output logic [31:0] d);
    cfg_addr = 6'(a); #1;
    d = cfg_rdata;
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #1000000;
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1 reset state
    rd(4, rv);  chk(rv == 0, "R1 enable", rv, 0);
    rd(16, rv); chk(rv == 0, "R1 map0", rv, 0);
    rd(3, rv);  chk(rv == 0, "R1 irq", rv, 0);
    chk(chan_pend == 0, "R1 pend", chan_pend, 0);
    // R3 status before master on
    rd(1, rv);  chk(rv == 32'h001F_0000, "R3 status off", rv, 32'h001F_0000);
    wr(0, 1);
    rd(1, rv);  chk(rv == 32'h001F_0001, "R3 status on", rv, 32'h001F_0001);
    rd(0, rv);  chk(rv == 1, "R3 cfg", rv, 1);

    // R2 set/clear pairs
    wr(4, 32'h0000_00A5);
    rd(5, rv); chk(rv == 32'hA5, "R2 read via clear", rv, 32'hA5);
    wr(4, 0);
    rd(4, rv); chk(rv == 32'hA5, "R2 zero set no effect", rv, 32'hA5);
    wr(5, 32'h05);
    rd(4, rv); chk(rv == 32'hA0, "R2 clear", rv, 32'hA0);
    wr(5, 32'hFFFF_FFFF);

    // vector table: routing, mask, enable, out-of-range select
    foreach (VEC[i]) begin
      automatic int wi = VEC[i].ch / 8;
      automatic int ls = 4 * (VEC[i].ch % 8);
      automatic logic [31:0] exp_v = 32'(VEC[i].exp) << VEC[i].ch;
      wr(16 + wi, 32'(VEC[i].sel) << ls);
      if (VEC[i].msk) wr(6, 32'd1 << VEC[i].ch);
      if (VEC[i].en)  wr(4, 32'd1 << VEC[i].ch);
      @(negedge clk);
      periph_req[VEC[i].ch*NSRC +: NSRC] = VEC[i].lines;
      #1;
      chk(chan_pend == exp_v, $sformatf("R7/R8/R4/R5 vector %0d", i), chan_pend, exp_v);
      periph_req = '0;
      wr(5, 32'hFFFF_FFFF);
      wr(7, 32'hFFFF_FFFF);
      wr(16 + wi, 0);
    end

    // R5 + R6: software request on a masked channel, one-shot
    wr(4, 32'h8);
    wr(6, 32'h8);
    wr(2, 32'h8);
    chk(chan_pend == 32'h8, "R5 sw on masked channel", chan_pend, 32'h8);
    @(posedge clk); #1;
    chk(chan_pend == 0, "R6 one-shot", chan_pend, 0);
    rd(2, rv); chk(rv == 0, "R6 swreq reads zero", rv, 0);

    // R4 master off blocks software request
    wr(0, 0);
    wr(2, 32'h8);
    chk(chan_pend == 0, "R4 master off", chan_pend, 0);
    wr(0, 1);
    wr(5, 32'hFFFF_FFFF);
    wr(7, 32'hFFFF_FFFF);

    // R9 burst hardware clear and collision
    wr(8, 32'h24);
    @(negedge clk); burst_drop = 32'h4;
    @(posedge clk); #1; burst_drop = '0;
    chk(chan_burst == 32'h20, "R9 hw clear", chan_burst, 32'h20);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = 6'd8; cfg_wdata = 32'h4; burst_drop = 32'h4;
    @(posedge clk); #1; cfg_we = 1'b0; burst_drop = '0;
    rd(9, rv); chk(rv == 32'h24, "R9 set wins", rv, 32'h24);

    // R10 interrupt status
    @(negedge clk); xfer_done = 32'h10;
    @(posedge clk); #1; xfer_done = '0;
    chk(chan_irq == 32'h10, "R10 done sets", chan_irq, 32'h10);
    wr(3, 32'h10);
    rd(3, rv); chk(rv == 0, "R10 w1c", rv, 0);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = 6'd3; cfg_wdata = 32'h10; xfer_done = 32'h10;
    @(posedge clk); #1; cfg_we = 1'b0; xfer_done = '0;
    chk(chan_irq == 32'h10, "R10 done wins", chan_irq, 32'h10);

    // R11 mirrors
    wr(12, 32'h8000_0001);
    wr(10, 32'h0000_0100);
    chk(chan_hipri == 32'h8000_0001, "R11 priority", chan_hipri, 32'h8000_0001);
    chk(chan_alt == 32'h100, "R11 alternate", chan_alt, 32'h100);
    wr(13, 32'h1);
    chk(chan_hipri == 32'h8000_0000, "R11 priority clear", chan_hipri, 32'h8000_0000);

    // R12 unmapped offsets
    wr(14, 32'hFFFF_FFFF);
    rd(14, rv); chk(rv == 0, "R12 unmapped read", rv, 0);
    wr(40, 32'hFFFF_FFFF);
    rd(4, rv);  chk(rv == 0, "R12 enable untouched", rv, 0);
    rd(6, rv);  chk(rv == 0, "R12 mask untouched", rv, 0);

    finish_run();
  end
endmodule